// File: doc/BRIEF.md
# Prioritized Interrupt Code Register

This block sits beside a two-wire serial bus controller and collects seven kinds of controller event into pending flags. It also presents a 3-bit code that names one pending, enabled event. Each event is a one-cycle pulse from the protocol engine. The pulse sets its flag. When the code register holds zero, it loads the code of the highest-priority event that is both pending and enabled.

Software consumes events by reading the code. A CPU read empties the code register. Three event kinds (arbitration lost, missing acknowledge, stop seen) also lose their pending flag on that read. The code register then advances to the next lower-priority event that is pending and enabled. A debugger may read the same code through a separate strobe that has no side effect. A single request line is raised while any enabled flag is pending.

Top module: `irq_code_reg`

## Requirements
- R1: A synchronous active-high `rst` clears every flag and sets the code to 000 at the next clock edge. Reset overrides event pulses in the same cycle.
- R2: Flag bit i maps to code i+1: 1 arbitration lost, 2 no acknowledge, 3 registers ready, 4 receive ready, 5 transmit ready, 6 stop detected, 7 addressed as slave. A pulse on `evt_i[i]` sets `flags_o[i]` at the next edge. The flag stays set until something clears it.
- R3: While the code is 000, each edge loads the lowest-numbered code whose flag is set and whose `en_i` bit is 1. If there is none, the code stays 000. Code 1 has the highest priority.
- R4: A flag whose enable bit is 0 never selects a code.
- R5: A CPU read (`rd_i`=1, `dbg_rd_i`=0) of a nonzero code c loads, at the next edge, the lowest code above c that is pending and enabled. If no such code exists, it loads 000. A CPU read while the code is 000 acts as a normal load.
- R6: A CPU read of code 1, 2 or 6 clears flag bit 0, 1 or 5 respectively. A read of any other code leaves every flag unchanged.
- R7: `w1c_i[i]`=1 clears `flags_o[i]`. A flag cleared this way in the same cycle is not a candidate for the code load.
- R8: When an event pulse and a clear hit the same flag in the same cycle, the flag ends set.
- R9: `dbg_rd_i`=1 changes neither code nor flags. If `rd_i` is also 1 in that cycle, the read has no side effect.
- R10: `irq_o` is 1 exactly when some bit is set in both `flags_o` and `en_i`.
- R11: A nonzero code holds its value until a CPU read or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 7 | Event pulses, bit i for code i+1 |
| en_i | input | 7 | Per-event enable mask |
| rd_i | input | 1 | CPU read strobe of the code |
| dbg_rd_i | input | 1 | Side-effect-free debug read strobe |
| w1c_i | input | 7 | Per-flag write-one-to-clear |
| code_o | output | 3 | Current interrupt code |
| flags_o | output | 7 | Pending flag vector |
| irq_o | output | 1 | Request: any enabled flag pending |

## Verification
Two functions can collide on one flag in one cycle: a consuming read that clears a flag, and a fresh event pulse that sets the same flag. The stimulus table provokes this by pulsing the stop event while the stop code is being read. The expected flag vector must still hold that bit. The code must also advance past the consumed code. The second collision is a debug read together with a CPU read. The code and flags are judged to be unchanged at the following edge.

// File: rtl/irq_code_reg.sv
module irq_code_reg #(
  parameter int NEV = 7,
  parameter logic [NEV-1:0] AUTOCLR = 7'b0100011
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] evt_i,
  input  logic [NEV-1:0] en_i,
  input  logic           rd_i,
  input  logic           dbg_rd_i,
  input  logic [NEV-1:0] w1c_i,
  output logic [2:0]     code_o,
  output logic [NEV-1:0] flags_o,
  output logic           irq_o
);
  localparam int CW = $clog2(NEV + 1);

  logic [NEV-1:0] flags_q, rd_clr, pool;
  logic [CW-1:0]  code_q, code_pick;
  logic           consume;

  assign consume = rd_i & ~dbg_rd_i;
  assign rd_clr  = (consume && code_q != '0)
                 ? (AUTOCLR & ({{(NEV-1){1'b0}}, 1'b1} << (code_q - 1'b1)))
                 : '0;
  assign pool    = flags_q & ~w1c_i & en_i & ({NEV{1'b1}} << code_q);

  always_comb begin
    code_pick = '0;
    for (int i = NEV - 1; i >= 0; i--)
      if (pool[i]) code_pick = CW'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      code_q  <= '0;
    end else begin
      flags_q <= (flags_q & ~(w1c_i | rd_clr)) | evt_i;
      if (consume || code_q == '0) code_q <= code_pick;
    end
  end

  assign code_o  = 3'(code_q);
  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);
endmodule

module irq_code_reg_chk #(parameter int NEV = 7) (
  input logic           clk,
  input logic           rst,
  input logic [NEV-1:0] evt_i,
  input logic [NEV-1:0] en_i,
  input logic           rd_i,
  input logic           dbg_rd_i,
  input logic [NEV-1:0] w1c_i,
  input logic [2:0]     code_o,
  input logic [NEV-1:0] flags_o,
  input logic           irq_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (code_o == 3'd0 && flags_o == '0));
  // R8
  event_sets_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_o & $past(evt_i)) == $past(evt_i)));
  // R11
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (code_o != 3'd0 && !(rd_i && !dbg_rd_i)) |=> $stable(code_o));
  // R9
  dbg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_rd_i && code_o != 3'd0 && evt_i == '0 && w1c_i == '0) |=> ($stable(code_o) && $stable(flags_o)));
  // R5
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !dbg_rd_i && code_o != 3'd0) |=> (code_o == 3'd0 || code_o > $past(code_o)));
  // R6
  keep_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !dbg_rd_i && code_o == 3'd4 && flags_o[3] && !w1c_i[3]) |=> flags_o[3]);
  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst) irq_o |-> (flags_o != '0));
endmodule

bind irq_code_reg irq_code_reg_chk #(.NEV(NEV)) chk_i (.*);

// File: tb/irq_code_reg_tb_top.sv
`timescale 1ns/1ps
module irq_code_reg_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic [6:0] evt_i = '0, en_i = '0, w1c_i = '0;
  logic rd_i = 1'b0, dbg_rd_i = 1'b0;
  logic [2:0] code_o;
  logic [6:0] flags_o;
  logic irq_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  irq_code_reg dut_i (.clk, .rst, .evt_i, .en_i, .rd_i, .dbg_rd_i, .w1c_i,
                      .code_o, .flags_o, .irq_o);

  // {evt, en, rd, dbg, w1c, exp_flags, exp_code}
  localparam int NV = 20;
  localparam logic [32:0] TBL [NV] = '{
    {7'h05, 7'h7F, 1'b0, 1'b0, 7'h00, 7'h05, 3'd0}, // R2
    {7'h00, 7'h7F, 1'b0, 1'b0, 7'h00, 7'h05, 3'd1}, // R3
    {7'h00, 7'h7F, 1'b1, 1'b0, 7'h00, 7'h04, 3'd3}, // R5 R6
    {7'h00, 7'h7F, 1'b1, 1'b0, 7'h00, 7'h04, 3'd0}, // R6 keep
    {7'h00, 7'h7F, 1'b0, 1'b0, 7'h00, 7'h04, 3'd3},
    {7'h00, 7'h7F, 1'b1, 1'b0, 7'h04, 7'h00, 3'd0}, // R7
    {7'h60, 7'h7F, 1'b0, 1'b0, 7'h00, 7'h60, 3'd0},
    {7'h00, 7'h1F, 1'b0, 1'b0, 7'h00, 7'h60, 3'd0}, // R4
    {7'h00, 7'h7F, 1'b0, 1'b0, 7'h00, 7'h60, 3'd6},
    {7'h20, 7'h7F, 1'b1, 1'b0, 7'h00, 7'h60, 3'd7}, // R8
    {7'h00, 7'h7F, 1'b0, 1'b1, 7'h00, 7'h60, 3'd7}, // R9
    {7'h00, 7'h7F, 1'b1, 1'b1, 7'h00, 7'h60, 3'd7}, // R9
    {7'h00, 7'h7F, 1'b1, 1'b0, 7'h00, 7'h60, 3'd0},
    {7'h00, 7'h7F, 1'b1, 1'b0, 7'h00, 7'h60, 3'd6}, // R5 read at 000
    {7'h00, 7'h7F, 1'b1, 1'b0, 7'h00, 7'h40, 3'd7},
    {7'h02, 7'h7F, 1'b0, 1'b0, 7'h00, 7'h42, 3'd7}, // R11
    {7'h00, 7'h7F, 1'b1, 1'b0, 7'h00, 7'h42, 3'd0},
    {7'h00, 7'h7F, 1'b0, 1'b0, 7'h00, 7'h42, 3'd2},
    {7'h00, 7'h7F, 1'b1, 1'b0, 7'h00, 7'h40, 3'd7},
    {7'h00, 7'h7F, 1'b1, 1'b0, 7'h40, 7'h00, 3'd0}
  };

  task automatic chk(string req, logic [6:0] ef, logic [2:0] ec);
    checks++;
    if (flags_o !== ef || code_o !== ec) begin
      fails++;
      $display("FAIL %s: flags=%h code=%0d expected flags=%h code=%0d", req, flags_o, code_o, ef, ec);
    end
    checks++;
    if (irq_o !== |(ef & en_i)) begin
      fails++;
      $display("FAIL R10: irq=%b expected %b", irq_o, |(ef & en_i));
    end
  endtask

  task automatic drive(logic [6:0] e, logic [6:0] n, logic r, logic d, logic [6:0] w);
    @(negedge clk);
    evt_i = e; en_i = n; rd_i = r; dbg_rd_i = d; w1c_i = w;
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    en_i = 7'h7F;
    evt_i = 7'h7F;
    @(posedge clk); #1;
    chk("R1", 7'h00, 3'd0);
    drive(7'h00, 7'h7F, 1'b0, 1'b0, 7'h00);
    rst = 1'b0;
    chk("R1", 7'h00, 3'd0);

    for (int v = 0; v < NV; v++) begin
      drive(TBL[v][32:26], TBL[v][25:19], TBL[v][18], TBL[v][17], TBL[v][16:10]);
      chk($sformatf("R2-table row %0d", v), TBL[v][9:3], TBL[v][2:0]);
    end

    for (int k = 0; k < 7; k++) begin
      drive(7'(1 << k), 7'h7F, 1'b0, 1'b0, 7'h00);
      drive(7'h00, 7'h7F, 1'b0, 1'b0, 7'h00);
      chk("R3 single event", 7'(1 << k), 3'(k + 1));
      drive(7'h00, 7'h7F, 1'b1, 1'b0, 7'(1 << k));
      chk("R7 clear", 7'h00, 3'd0);
    end

    drive(7'h48, 7'h7F, 1'b0, 1'b0, 7'h00);
    drive(7'h00, 7'h7F, 1'b0, 1'b0, 7'h00);
    chk("R3 two pending", 7'h48, 3'd4);
    drive(7'h00, 7'h7F, 1'b1, 1'b0, 7'h00);
    chk("R6 no clear on code 4", 7'h48, 3'd7);
    @(negedge clk);
    rst = 1'b1; evt_i = 7'h11;
    @(posedge clk); #1;
    chk("R1 reset over event", 7'h00, 3'd0);
    @(negedge clk);
    rst = 1'b0; evt_i = '0;
    @(posedge clk); #1;
    chk("R1 after reset", 7'h00, 3'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule